// File: doc/BRIEF.md
# MSI Remap Request Translator

This block sits on the inbound interrupt-write path. It takes a message-signalled interrupt write, made of a 64-bit address, a 32-bit data word, an access size and the requester ID, and decides what becomes of it. A request can pass through unchanged, be dropped with an error pulse, or be turned into a table lookup. A lookup request carries an entry index and the requester ID to an external entry validator. When the validator answers with the entry fields, the block builds a compatibility-format message from them.

Remapping can be switched off as a whole. A request in compatibility format is also forwarded untouched. The handle in a remappable request is split across two address fields, and it may be offset by a subhandle taken from the data word. The block reads one request at a time and holds `req_ready_o` low while a lookup is outstanding.

Top module: `msi_remap_xlate`

## Requirements
- R1: A request whose access size `req_size_i` is not 4 bytes is dropped. This applies whether remapping is on or off: `err_o` pulses and no output or lookup follows.
- R2: With `remap_en_i` low, an accepted 4-byte request appears on `out_addr_o`/`out_data_o` unchanged, with `out_valid_o` high in the cycle after acceptance.
- R3: With remapping on, a request with any nonzero bit in address bits 63:32 is dropped with `err_o`.
- R4: With remapping on, a request whose address bits 31:20 differ from 0xFEE is dropped with `err_o`.
- R5: With remapping on, a request with address bit 4 (format bit) at 0 is in compatibility format and is forwarded unchanged, with no lookup.
- R6: A remappable request (address bit 4 at 1) issues one lookup pulse on `lkp_valid_o`, in the cycle after acceptance. The lookup carries index {addr[2], addr[19:5]} and the request's requester ID.
- R7: When address bit 3 (subhandle valid) is set, data bits 15:0 are added to the index, modulo 2^16. If data bits 31:16 are then nonzero, the request is dropped with `err_o` and no lookup is issued.
- R8: A lookup response with `rsp_fault_i` high drops the request with `err_o`, in the cycle after the response.
- R9: A successful response yields `out_addr_o` with bits 63:32 zero, bits 31:20 = 0xFEE, bits 19:12 = destination, bits 11:4 zero, bit 3 = redirection hint, bit 2 = destination mode, and bits 1:0 copied from the request.
- R10: A successful response yields `out_data_o` with bits 7:0 = vector, bits 10:8 = delivery mode, bits 13:11 zero, bit 14 = 1 (level), bit 15 = trigger mode, and bits 31:16 zero.
- R11: `out_valid_o` and `err_o` are never high together. `lkp_valid_o` is a single-cycle pulse, and `req_ready_o` stays low from that pulse until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| remap_en_i | input | 1 | Global remapping enable |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_size_i | input | 3 | Access size in bytes |
| req_addr_i | input | 64 | Interrupt write address |
| req_data_i | input | 32 | Interrupt write data |
| req_rid_i | input | 16 | Requester ID |
| lkp_valid_o | output | 1 | Lookup request pulse |
| lkp_index_o | output | 16 | Table index to look up |
| lkp_rid_o | output | 16 | Requester ID for source validation |
| rsp_valid_i | input | 1 | Lookup response present |
| rsp_fault_i | input | 1 | Entry lookup or validation failed |
| rsp_vector_i | input | 8 | Entry vector |
| rsp_dlv_mode_i | input | 3 | Entry delivery mode |
| rsp_trig_i | input | 1 | Entry trigger mode |
| rsp_dest_i | input | 8 | Entry destination |
| rsp_dest_mode_i | input | 1 | Entry destination mode |
| rsp_redir_hint_i | input | 1 | Entry redirection hint |
| out_valid_o | output | 1 | Output message pulse |
| out_addr_o | output | 64 | Output message address |
| out_data_o | output | 32 | Output message data |
| err_o | output | 1 | Request dropped pulse |

## Verification
The hardest case to reach from the ports is the subhandle sum that wraps past 0xFFFF. To produce it, the two address handle fields must be all ones and a data subhandle must be chosen at the same time. Random addresses almost never land there, so a directed request sets handle 0xFFFF with subhandle 2 and expects index 1. Random requests also keep the window and upper address bits legal most of the time, so that most of them get deep enough to reach a lookup. Faulting entries are chosen by index, so the fault path is taken through ordinary stimulus.

// File: rtl/msi_remap_pkg.sv
package msi_remap_pkg;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned DLV_W  = 3;
  localparam int unsigned DEST_W = 8;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned SUB_W  = 16;

  localparam logic [11:0]       MSI_WINDOW = 12'hFEE;
  localparam logic [SIZE_W-1:0] ACC_BYTES  = 3'd4;

  typedef enum logic [1:0] {
    CLS_PASS   = 2'd0,
    CLS_DROP   = 2'd1,
    CLS_LOOKUP = 2'd2
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DLV_W-1:0]  dlv;
    logic              trig;
    logic [DEST_W-1:0] dest;
    logic              dest_mode;
    logic              redir;
  } ent_t;
endpackage

// File: rtl/msi_remap_decode.sv
module msi_remap_decode
  import msi_remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic              en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:2] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output cls_e              cls_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic             hi_nz, win_ok, is_remap, shv, rsvd;
  logic [IDX_W-1:0] handle, sub;

  assign hi_nz    = |addr_i[ADDR_W-1:32];
  assign win_ok   = (addr_i[31:20] == MSI_WINDOW);
  assign is_remap = addr_i[4];
  assign shv      = addr_i[3];
  assign handle   = {addr_i[2], addr_i[19:5]};
  assign sub      = shv ? IDX_W'(data_i[SUB_W-1:0]) : '0;
  assign idx_o    = handle + sub;
  assign rsvd     = shv && (|data_i[DATA_W-1:SUB_W]);

  always_comb begin
    if (size_i != ACC_BYTES)    cls_o = CLS_DROP;
    else if (!en_i)             cls_o = CLS_PASS;
    else if (hi_nz || !win_ok)  cls_o = CLS_DROP;
    else if (!is_remap)         cls_o = CLS_PASS;
    else if (rsvd)              cls_o = CLS_DROP;
    else                        cls_o = CLS_LOOKUP;
  end
endmodule

// File: rtl/msi_remap_build.sv
module msi_remap_build
  import msi_remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32
) (
  input  ent_t              ent_i,
  input  logic [1:0]        low_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    addr_o               = '0;
    addr_o[31:20]        = MSI_WINDOW;
    addr_o[12 +: DEST_W] = ent_i.dest;
    addr_o[3]            = ent_i.redir;
    addr_o[2]            = ent_i.dest_mode;
    addr_o[1:0]          = low_i;

    data_o              = '0;
    data_o[0 +: VEC_W]  = ent_i.vector;
    data_o[8 +: DLV_W]  = ent_i.dlv;
    data_o[14]          = 1'b1;
    data_o[15]          = ent_i.trig;
  end
endmodule

// File: rtl/msi_remap_ctrl.sv
module msi_remap_ctrl
  import msi_remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  cls_e              cls_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [RID_W-1:0]  rid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_fault_i,
  input  logic [ADDR_W-1:0] bld_addr_i,
  input  logic [DATA_W-1:0] bld_data_i,
  output logic              ready_o,
  output logic              lkp_valid_o,
  output logic [IDX_W-1:0]  lkp_idx_o,
  output logic [RID_W-1:0]  lkp_rid_o,
  output logic [1:0]        low_o,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);
  st_e state_q;

  assign ready_o     = (state_q == ST_IDLE);
  assign lkp_valid_o = (state_q == ST_ISSUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lkp_idx_o   <= '0;
      lkp_rid_o   <= '0;
      low_o       <= '0;
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
      out_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      err_o       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fire_i) begin
            unique case (cls_i)
              CLS_PASS: begin
                out_valid_o <= 1'b1;
                out_addr_o  <= addr_i;
                out_data_o  <= data_i;
              end
              CLS_LOOKUP: begin
                lkp_idx_o <= idx_i;
                lkp_rid_o <= rid_i;
                low_o     <= addr_i[1:0];
                state_q   <= ST_ISSUE;
              end
              default: err_o <= 1'b1;
            endcase
          end
        end
        ST_ISSUE, ST_WAIT: begin
          if (rsp_valid_i) begin
            state_q <= ST_IDLE;
            if (rsp_fault_i) begin
              err_o <= 1'b1;
            end else begin
              out_valid_o <= 1'b1;
              out_addr_o  <= bld_addr_i;
              out_data_o  <= bld_data_i;
            end
          end else begin
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_remap_xlate.sv
module msi_remap_xlate
  import msi_remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              remap_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [RID_W-1:0]  req_rid_i,
  output logic              lkp_valid_o,
  output logic [IDX_W-1:0]  lkp_index_o,
  output logic [RID_W-1:0]  lkp_rid_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_fault_i,
  input  logic [VEC_W-1:0]  rsp_vector_i,
  input  logic [DLV_W-1:0]  rsp_dlv_mode_i,
  input  logic              rsp_trig_i,
  input  logic [DEST_W-1:0] rsp_dest_i,
  input  logic              rsp_dest_mode_i,
  input  logic              rsp_redir_hint_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);
  cls_e              cls;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        low;
  logic [ADDR_W-1:0] bld_addr;
  logic [DATA_W-1:0] bld_data;
  ent_t              ent;

  assign ent = '{vector: rsp_vector_i, dlv: rsp_dlv_mode_i, trig: rsp_trig_i,
                 dest: rsp_dest_i, dest_mode: rsp_dest_mode_i,
                 redir: rsp_redir_hint_i};

  msi_remap_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .en_i   (remap_en_i),
    .size_i (req_size_i),
    .addr_i (req_addr_i[ADDR_W-1:2]),
    .data_i (req_data_i),
    .cls_o  (cls),
    .idx_o  (idx)
  );

  msi_remap_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_build (
    .ent_i  (ent),
    .low_i  (low),
    .addr_o (bld_addr),
    .data_o (bld_data)
  );

  msi_remap_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RID_W(RID_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (req_valid_i && req_ready_o),
    .cls_i       (cls),
    .idx_i       (idx),
    .rid_i       (req_rid_i),
    .addr_i      (req_addr_i),
    .data_i      (req_data_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_fault_i (rsp_fault_i),
    .bld_addr_i  (bld_addr),
    .bld_data_i  (bld_data),
    .ready_o     (req_ready_o),
    .lkp_valid_o (lkp_valid_o),
    .lkp_idx_o   (lkp_index_o),
    .lkp_rid_o   (lkp_rid_o),
    .low_o       (low),
    .out_valid_o (out_valid_o),
    .out_addr_o  (out_addr_o),
    .out_data_o  (out_data_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/msi_remap_checker.sv
module msi_remap_checker
  import msi_remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              remap_en_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [SIZE_W-1:0] req_size_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_data_i,
  input logic              lkp_valid_o,
  input logic [IDX_W-1:0]  lkp_index_o,
  input logic              rsp_valid_i,
  input logic              rsp_fault_i,
  input logic [DEST_W-1:0] rsp_dest_i,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              err_o
);
  logic acc, acc4, legal_win;
  assign acc       = req_valid_i && req_ready_o;
  assign acc4      = acc && (req_size_i == ACC_BYTES);
  assign legal_win = (req_addr_i[ADDR_W-1:32] == '0) && (req_addr_i[31:20] == MSI_WINDOW);

  assert_size_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_size_i != ACC_BYTES) |=> (err_o && !out_valid_o));

  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc4 && !remap_en_i) |=> (out_valid_o && out_addr_o == $past(req_addr_i)
                                && out_data_o == $past(req_data_i)));

  assert_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc4 && remap_en_i && (|req_addr_i[ADDR_W-1:32])) |=> err_o);

  assert_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc4 && remap_en_i && req_addr_i[31:20] != MSI_WINDOW) |=> err_o);

  assert_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc4 && remap_en_i && legal_win && req_addr_i[4] && !req_addr_i[3])
    |=> (lkp_valid_o && lkp_index_o == {$past(req_addr_i[2]), $past(req_addr_i[19:5])}));

  assert_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && rsp_valid_i && rsp_fault_i) |=> (err_o && !out_valid_o));

  assert_build_R9_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && rsp_valid_i && !rsp_fault_i)
    |=> (out_valid_o && out_addr_o[31:20] == MSI_WINDOW && out_addr_o[ADDR_W-1:32] == '0
         && out_addr_o[19:12] == $past(rsp_dest_i) && out_data_o[14]));

  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && err_o));

  assert_lkp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_o |=> !lkp_valid_o);

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_o |-> !req_ready_o);
endmodule

bind msi_remap_xlate msi_remap_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/msi_remap_xlate_bench.sv
`timescale 1ns/1ps
module msi_remap_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        remap_en = 1'b0, req_valid = 1'b0, req_ready;
  logic [2:0]  req_size = 3'd4;
  logic [63:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [15:0] req_rid = '0;
  logic        lkp_valid;
  logic [15:0] lkp_index, lkp_rid;
  logic        rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [7:0]  rsp_vector = '0, rsp_dest = '0;
  logic [2:0]  rsp_dlv = '0;
  logic        rsp_trig = 1'b0, rsp_dm = 1'b0, rsp_rh = 1'b0;
  logic        out_valid, err;
  logic [63:0] out_addr;
  logic [31:0] out_data;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  msi_remap_xlate u_msi_remap_xlate (
    .clk_i(clk), .rst_ni(rst_n), .remap_en_i(remap_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_rid_i(req_rid),
    .lkp_valid_o(lkp_valid), .lkp_index_o(lkp_index), .lkp_rid_o(lkp_rid),
    .rsp_valid_i(rsp_valid), .rsp_fault_i(rsp_fault), .rsp_vector_i(rsp_vector),
    .rsp_dlv_mode_i(rsp_dlv), .rsp_trig_i(rsp_trig), .rsp_dest_i(rsp_dest),
    .rsp_dest_mode_i(rsp_dm), .rsp_redir_hint_i(rsp_rh),
    .out_valid_o(out_valid), .out_addr_o(out_addr), .out_data_o(out_data), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // reason: 0 bypass R2, 1 compat R5, 2 size R1, 3 upper R3, 4 window R4, 5 rsvd data R7, 6 lookup
  function automatic int classify(input logic en, input logic [63:0] a, input logic [31:0] d, input logic [2:0] s);
    if (s != 3'd4) return 2;
    if (!en) return 0;
    if (a[63:32] != 0) return 3;
    if (a[31:20] != 12'hFEE) return 4;
    if (!a[4]) return 1;
    if (a[3] && d[31:16] != 0) return 5;
    return 6;
  endfunction

  function automatic logic [15:0] exp_index(input logic [63:0] a, input logic [31:0] d);
    logic [15:0] h;
    h = {a[2], a[19:5]};
    return a[3] ? h + d[15:0] : h;
  endfunction

  function automatic bit ent_fault(input logic [15:0] i);
    return i[4:0] == 5'd7;
  endfunction

  task automatic run_tx(input logic en, input logic [63:0] a, input logic [31:0] d,
                        input logic [15:0] rid, input logic [2:0] s);
    int          why;
    bit          got_out, got_err, got_lkp, both;
    logic [15:0] li, lr, ei;
    logic [63:0] oa, ea;
    logic [31:0] od, ed;
    string       tag;
    why = classify(en, a, d, s);
    ei  = exp_index(a, d);
    got_out = 0; got_err = 0; got_lkp = 0; both = 0;
    li = '0; lr = '0; oa = '0; od = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    remap_en = en; req_addr = a; req_data = d; req_rid = rid; req_size = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 30; c++) begin
      rsp_valid = 1'b0;
      if (out_valid && err) both = 1;
      if (out_valid) begin got_out = 1; oa = out_addr; od = out_data; break; end
      if (err) begin got_err = 1; break; end
      if (lkp_valid) begin
        got_lkp = 1; li = lkp_index; lr = lkp_rid;
        chk(!req_ready, "R11 busy during lookup", {63'd0, req_ready}, 64'd0);
        repeat ($urandom % 3) @(negedge clk);
        rsp_fault  = ent_fault(lkp_index);
        rsp_vector = lkp_index[7:0] ^ 8'h5A;
        rsp_dlv    = lkp_index[10:8];
        rsp_trig   = lkp_index[11];
        rsp_dest   = lkp_index[15:8] ^ 8'h3C;
        rsp_dm     = lkp_index[12];
        rsp_rh     = lkp_index[13];
        rsp_valid  = 1'b1;
      end
      @(negedge clk);
    end
    rsp_valid = 1'b0;
    chk(!both, "R11 out and err together", {63'd0, both}, 64'd0);
    case (why)
      0, 1: begin
        tag = (why == 0) ? "R2 bypass" : "R5 compat passthrough";
        chk(got_out && !got_lkp, tag, {62'd0, got_lkp, got_out}, 64'd1);
        chk(oa == a, tag, oa, a);
        chk(od == d, tag, {32'd0, od}, {32'd0, d});
      end
      2, 3, 4, 5: begin
        tag = (why == 2) ? "R1 size drop" : (why == 3) ? "R3 upper drop" :
              (why == 4) ? "R4 window drop" : "R7 rsvd data drop";
        chk(got_err && !got_out && !got_lkp, tag, {61'd0, got_lkp, got_out, got_err}, 64'd1);
      end
      default: begin
        tag = a[3] ? "R7 subhandle index" : "R6 index";
        chk(got_lkp && li == ei, tag, {48'd0, li}, {48'd0, ei});
        chk(lr == rid, "R6 rid", {48'd0, lr}, {48'd0, rid});
        if (ent_fault(ei)) begin
          chk(got_err && !got_out, "R8 fault drop", {62'd0, got_out, got_err}, 64'd1);
        end else begin
          ea = {32'd0, 12'hFEE, ei[15:8] ^ 8'h3C, 8'd0, ei[13], ei[12], a[1:0]};
          ed = {16'd0, ei[11], 1'b1, 3'd0, ei[10:8], ei[7:0] ^ 8'h5A};
          chk(got_out, "R9 output present", {63'd0, got_out}, 64'd1);
          chk(oa == ea, "R9 address", oa, ea);
          chk(od == ed, "R10 data", {32'd0, od}, {32'd0, ed});
        end
      end
    endcase
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!out_valid && !err && !lkp_valid, "R11 reset outputs",
        {61'd0, out_valid, err, lkp_valid}, 64'd0);
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R11 reset ready", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R11 ready after reset", {63'd0, req_ready}, 64'd1);

    // directed corners
    run_tx(1'b0, 64'hDEAD_BEEF_0000_0013, 32'hFFFF_FFFF, 16'h0101, 3'd4); // R2 garbage
    run_tx(1'b1, 64'h0000_0000_FEE0_0018, 32'h0, 16'h0102, 3'd2);        // R1
    run_tx(1'b0, 64'h0000_0000_FEE0_0018, 32'h0, 16'h0103, 3'd8);        // R1 disabled
    run_tx(1'b1, 64'h0000_0001_FEE0_0010, 32'h0, 16'h0104, 3'd4);        // R3
    run_tx(1'b1, 64'h0000_0000_FED0_0010, 32'h0, 16'h0105, 3'd4);        // R4
    run_tx(1'b1, 64'h0000_0000_FEE1_2343, 32'h0000_0041, 16'h0106, 3'd4); // R5
    run_tx(1'b1, 64'h0000_0000_FEE0_0034, 32'h0, 16'h0107, 3'd4);        // R6 idx 0x8001
    run_tx(1'b1, 64'h0000_0000_FEEF_FFFE, 32'h0000_0002, 16'h0108, 3'd4); // R7 wrap -> 1
    run_tx(1'b1, 64'h0000_0000_FEE0_0018, 32'h0001_0000, 16'h0109, 3'd4); // R7 rsvd
    run_tx(1'b1, 64'h0000_0000_FEE0_00F1, 32'h0, 16'h010A, 3'd4);        // R8 idx 7

    for (int n = 0; n < 600; n++) begin
      logic [63:0] a;
      logic [31:0] d;
      logic [2:0]  s;
      logic        en;
      a[63:32] = ($urandom % 12 == 0) ? $urandom : 32'd0;
      a[31:20] = ($urandom % 10 == 0) ? 12'($urandom) : 12'hFEE;
      a[19:0]  = 20'($urandom);
      if ($urandom % 5 != 0) a[4] = 1'b1;
      d = $urandom;
      if (a[3] && ($urandom % 6 != 0)) d[31:16] = '0;
      s  = ($urandom % 10 == 0) ? 3'($urandom) : 3'd4;
      en = ($urandom % 8 != 0);
      run_tx(en, a, d, 16'($urandom), s);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule